// File: doc/BRIEF.md
# Message receive handshake controller

This block is the host-side sequencer that collects one message from a peripheral. The two sides share a receive status byte and a data port that is 8 or 16 bits wide. The caller pulses `start` with a poll limit and a port width. The controller then waits for the peripheral to report that a message is ready. It reads the message length, in one word or in two byte phases, and presents the length for one cycle. Next it asks for the payload, streams the payload bytes out over a valid/ready handshake, and closes the exchange with a completion code.

Each status code that the controller writes goes with a one-cycle interrupt pulse toward the peripheral. All waits are counted in `tick` intervals. The request stage uses the caller's limit and the later stages use a fixed parameter limit. If a wait runs out, or the peripheral answers with a refusal or with the ready code of the other width, the controller returns to idle with `err` set (and `nak` for a refusal). When the length is odd, the port still delivers an even number of bytes. The surplus byte is kept on a residual output and is not streamed.

Top module: `rx_handshake_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every strobe (`stat_wr`, `rx_irq`, `data_rd`, `len_valid`, `out_valid`, `done`) and the flags `err`, `nak` and `resid_valid` are low.
- R2: After `start` the controller polls `stat_in` until a ready code arrives: 0x10 in 16-bit mode, 0x60 in 8-bit mode. If `poll_limit` ticks pass first, it sets `err` without `nak`, and it reads nothing and writes nothing.
- R3: In 16-bit mode the length is taken from one read of `data_in`. Every length is shown on `len_out` with `len_valid` high for exactly one cycle.
- R4: In 8-bit mode the low length byte is read from `data_in[7:0]`. The controller then writes 0x70, waits up to `STAGE_LIMIT` ticks for 0x10 and reads the high length byte.
- R5: Status 0x50 during the request stage sets both `err` and `nak`. The ready code of the other width sets `err` only. Either one ends the attempt at once.
- R6: The data stage writes 0x20 and waits up to `STAGE_LIMIT` ticks for 0x40. On expiry it sets `err` and streams no byte.
- R7: Payload bytes leave on `out_data` in port order, low byte of each word first. A byte moves only when `out_valid` and `out_ready` are both high, and `out_valid`/`out_data` hold while `out_ready` is low.
- R8: For an odd length N, the port delivers N+1 bytes. Byte N+1 (the high byte of the last word in 16-bit mode, or one extra byte read in 8-bit mode) is not streamed. It appears on `resid_data` with `resid_valid` high until the next start. For an even length, `resid_valid` stays low.
- R9: After the last payload byte the controller writes 0x30 and pulses `done` for one cycle with `err` low. `start` clears `err`, `nak` and `resid_valid`.
- R10: Every status write (`stat_wr` high) carries `rx_irq` in the same cycle, and the only codes written are 0x70, 0x20 and 0x30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin receiving one message (ignored unless idle) |
| wide_mode | input | 1 | 1: 16-bit data port, 0: 8-bit data port; sampled at start |
| poll_limit | input | TW | Tick limit for the request stage; sampled at start |
| tick | input | 1 | One polling interval has elapsed |
| stat_in | input | 8 | Receive status byte read from the peripheral |
| stat_wr | output | 1 | Status write strobe |
| stat_wdata | output | 8 | Status code written |
| rx_irq | output | 1 | Interrupt pulse to the peripheral |
| data_rd | output | 1 | Data port read strobe; `data_in` is captured in that cycle |
| data_in | input | 16 | Data port read value |
| len_valid | output | 1 | Message length valid (one cycle) |
| len_out | output | 16 | Message length in bytes |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Sink accepts payload byte |
| out_data | output | 8 | Payload byte |
| resid_valid | output | 1 | Residual byte present |
| resid_data | output | 8 | Residual byte of an odd-length message |
| done | output | 1 | Message completed (one cycle) |
| err | output | 1 | Last attempt failed |
| nak | output | 1 | Last attempt was refused by the peripheral |

## Verification
A state machine stuck in or skipping a stage shows at the ports within one transaction. The status write sequence comes out in the wrong order or with a code missing, or `done` fails to arrive, or `err` appears when it should not. A miscounted byte counter shows up as a payload stream that is one byte short or long, or as a residual byte that does not match the pad value. A wrong byte order within a word is caught at the first streamed byte. A misloaded poll limit or stage limit moves the moment `err` rises, and the bench checks that it rises neither before the limit nor long after it.

// File: rtl/rx_hs_pkg.sv
// Package: shared state type and status codes for the receive handshake.
// Assumes an 8-bit status register shared by host and peripheral.
package rx_hs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REQ_POLL,
        S_LEN_WORD,
        S_LEN_LO,
        S_HI_REQ,
        S_HI_WAIT,
        S_LEN_HI,
        S_LEN_SHOW,
        S_DAT_REQ,
        S_DAT_WAIT,
        S_DAT_RD,
        S_PUSH_LO,
        S_PUSH_HI,
        S_RES_RD,
        S_END
    } rx_state_t;

    localparam logic [7:0] CODE_RDY_WIDE   = 8'h10;
    localparam logic [7:0] CODE_RDY_NARROW = 8'h60;
    localparam logic [7:0] CODE_REFUSED    = 8'h50;
    localparam logic [7:0] CODE_HI_ASK     = 8'h70;
    localparam logic [7:0] CODE_DATA_ASK   = 8'h20;
    localparam logic [7:0] CODE_DATA_GO    = 8'h40;
    localparam logic [7:0] CODE_FINISH     = 8'h30;

endpackage

// File: rtl/rx_wait_timer.sv
// Interval counter for bounded waits.
// Counts tick pulses from zero after clr drops; expired is high once the
// count has reached limit. Assumes limit is stable for the whole wait.
module rx_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    logic [TW-1:0] cnt;

    assign expired = (cnt >= limit);

    // count elapsed intervals, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rx_stat_decode.sv
// Classifies the receive status byte for the sequencer.
// Purely combinational; the width flag selects which ready code is valid.
module rx_stat_decode
    import rx_hs_pkg::*;
(
    input  logic [7:0] stat,
    input  logic       wide,
    output logic       rdy_ok,
    output logic       rdy_wrong,
    output logic       refused,
    output logic       hi_ok,
    output logic       data_ok
);

    // map the status byte onto per-stage match flags
    always_comb begin
        rdy_ok    = wide ? (stat == CODE_RDY_WIDE)   : (stat == CODE_RDY_NARROW);
        rdy_wrong = wide ? (stat == CODE_RDY_NARROW) : (stat == CODE_RDY_WIDE);
        refused   = (stat == CODE_REFUSED);
        hi_ok     = (stat == CODE_RDY_WIDE);
        data_ok   = (stat == CODE_DATA_GO);
    end

endmodule

// File: rtl/rx_handshake_ctrl.sv
// Receive handshake sequencer: request, length, data and end stages.
// Assumes data_in is valid in the cycle data_rd is high and that the
// peripheral advances its port after each read. Waits are bounded in tick
// intervals: poll_limit for the request stage, STAGE_LIMIT afterwards.
module rx_handshake_ctrl
    import rx_hs_pkg::*;
#(
    parameter int TW          = 16,
    parameter int LEN_W       = 16,
    parameter int STAGE_LIMIT = 600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wide_mode,
    input  logic [TW-1:0]    poll_limit,
    input  logic             tick,
    input  logic [7:0]       stat_in,
    output logic             stat_wr,
    output logic [7:0]       stat_wdata,
    output logic             rx_irq,
    output logic             data_rd,
    input  logic [15:0]      data_in,
    output logic             len_valid,
    output logic [LEN_W-1:0] len_out,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             resid_valid,
    output logic [7:0]       resid_data,
    output logic             done,
    output logic             err,
    output logic             nak
);

    localparam logic [TW-1:0]    STAGE_LIM = TW'(STAGE_LIMIT);
    localparam logic [LEN_W-1:0] ONE       = LEN_W'(1);

    rx_state_t        state;
    logic             wide_q;
    logic [TW-1:0]    lim_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] left;
    logic [15:0]      wbuf;

    logic          in_wait;
    logic          tmr_exp;
    logic [TW-1:0] tmr_lim;
    logic          sd_rdy, sd_wrong, sd_nak, sd_hi, sd_data;

    assign in_wait = (state == S_REQ_POLL) || (state == S_HI_WAIT) ||
                     (state == S_DAT_WAIT);
    assign tmr_lim = (state == S_REQ_POLL) ? lim_q : STAGE_LIM;

    rx_wait_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!in_wait),
        .tick    (tick),
        .limit   (tmr_lim),
        .expired (tmr_exp)
    );

    rx_stat_decode u_decode (
        .stat      (stat_in),
        .wide      (wide_q),
        .rdy_ok    (sd_rdy),
        .rdy_wrong (sd_wrong),
        .refused   (sd_nak),
        .hi_ok     (sd_hi),
        .data_ok   (sd_data)
    );

    // sequencer: stage transitions, length/payload capture, flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            wide_q      <= 1'b0;
            lim_q       <= '0;
            len_q       <= '0;
            left        <= '0;
            wbuf        <= '0;
            resid_valid <= 1'b0;
            resid_data  <= '0;
            err         <= 1'b0;
            nak         <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    wide_q      <= wide_mode;
                    lim_q       <= poll_limit;
                    err         <= 1'b0;
                    nak         <= 1'b0;
                    resid_valid <= 1'b0;
                    state       <= S_REQ_POLL;
                end
                S_REQ_POLL: begin
                    if (sd_nak) begin
                        err   <= 1'b1;
                        nak   <= 1'b1;
                        state <= S_IDLE;
                    end else if (sd_wrong) begin
                        err   <= 1'b1;
                        state <= S_IDLE;
                    end else if (sd_rdy) begin
                        state <= wide_q ? S_LEN_WORD : S_LEN_LO;
                    end else if (tmr_exp) begin
                        err   <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_LEN_WORD: begin
                    len_q <= LEN_W'(data_in);
                    state <= S_LEN_SHOW;
                end
                S_LEN_LO: begin
                    len_q <= LEN_W'(data_in[7:0]);
                    state <= S_HI_REQ;
                end
                S_HI_REQ: state <= S_HI_WAIT;
                S_HI_WAIT: begin
                    if (sd_hi) begin
                        state <= S_LEN_HI;
                    end else if (tmr_exp) begin
                        err   <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_LEN_HI: begin
                    len_q <= len_q | LEN_W'({data_in[7:0], 8'h00});
                    state <= S_LEN_SHOW;
                end
                S_LEN_SHOW: begin
                    left  <= len_q;
                    state <= S_DAT_REQ;
                end
                S_DAT_REQ: state <= S_DAT_WAIT;
                S_DAT_WAIT: begin
                    if (sd_data) begin
                        state <= (left == '0) ? S_END : S_DAT_RD;
                    end else if (tmr_exp) begin
                        err   <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_DAT_RD: begin
                    wbuf  <= data_in;
                    state <= S_PUSH_LO;
                end
                S_PUSH_LO: if (out_ready) begin
                    left <= left - ONE;
                    if (left == ONE) begin
                        if (wide_q) begin
                            resid_data  <= wbuf[15:8];
                            resid_valid <= 1'b1;
                            state       <= S_END;
                        end else begin
                            state <= len_q[0] ? S_RES_RD : S_END;
                        end
                    end else begin
                        state <= wide_q ? S_PUSH_HI : S_DAT_RD;
                    end
                end
                S_PUSH_HI: if (out_ready) begin
                    left  <= left - ONE;
                    state <= (left == ONE) ? S_END : S_DAT_RD;
                end
                S_RES_RD: begin
                    resid_data  <= data_in[7:0];
                    resid_valid <= 1'b1;
                    state       <= S_END;
                end
                S_END:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // strobes decoded from the current stage
    always_comb begin
        stat_wr    = 1'b0;
        stat_wdata = 8'h00;
        case (state)
            S_HI_REQ:  begin stat_wr = 1'b1; stat_wdata = CODE_HI_ASK;   end
            S_DAT_REQ: begin stat_wr = 1'b1; stat_wdata = CODE_DATA_ASK; end
            S_END:     begin stat_wr = 1'b1; stat_wdata = CODE_FINISH;   end
            default:   ;
        endcase
        rx_irq    = stat_wr;
        data_rd   = (state == S_LEN_WORD) || (state == S_LEN_LO) ||
                    (state == S_LEN_HI)   || (state == S_DAT_RD) ||
                    (state == S_RES_RD);
        len_valid = (state == S_LEN_SHOW);
        len_out   = len_q;
        out_valid = (state == S_PUSH_LO) || (state == S_PUSH_HI);
        out_data  = (state == S_PUSH_HI) ? wbuf[15:8] : wbuf[7:0];
        done      = (state == S_END);
    end

endmodule

// File: rtl/rx_handshake_chk.sv
// Port-level protocol checker for rx_handshake_ctrl, attached by bind.
// Observes only the block's ports; assumes synchronous active-low reset.
module rx_handshake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stat_wr,
    input logic [7:0] stat_wdata,
    input logic       data_rd,
    input logic       len_valid,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       done,
    input logic       err,
    input logic       nak
);

    // R3
    len_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |=> !len_valid);

    // R7
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R5
    nak_has_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nak |-> err);

    // R9
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!err && !out_valid));

    // R10
    write_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |-> (stat_wdata == 8'h20 || stat_wdata == 8'h30 ||
                     stat_wdata == 8'h70));

    // R2
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_wr, data_rd, len_valid, out_valid}));

endmodule

bind rx_handshake_ctrl rx_handshake_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .data_rd    (data_rd),
    .len_valid  (len_valid),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .done       (done),
    .err        (err),
    .nak        (nak)
);

// File: tb/test_rx_handshake_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected lengths, bytes and status
// writes; a negedge monitor pops and compares what the design produces.
module test_rx_handshake_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide_mode = 1'b0;
    logic [15:0] poll_limit = 16'd50;
    logic        tick = 1'b1;
    logic [7:0]  stat_in = 8'h00;
    logic [15:0] data_in = 16'h0000;
    logic        out_ready = 1'b0;
    logic        stat_wr, rx_irq, data_rd, len_valid, out_valid;
    logic        resid_valid, done, err, nak;
    logic [7:0]  stat_wdata, out_data, resid_data;
    logic [15:0] len_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rcnt = 0;

    logic [15:0] pq[$];
    logic [15:0] exp_len[$];
    logic [7:0]  exp_byte[$];
    logic [7:0]  exp_wr[$];

    logic [7:0] pend_stat = 8'h00;
    bit go_tgl = 1'b0;
    bit go_seen = 1'b0;
    bit hang_data = 1'b0;

    always #2.5 clk = ~clk;

    rx_handshake_ctrl i_rx_handshake_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
        .poll_limit(poll_limit), .tick(tick), .stat_in(stat_in),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .rx_irq(rx_irq),
        .data_rd(data_rd), .data_in(data_in), .len_valid(len_valid),
        .len_out(len_out), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .resid_valid(resid_valid),
        .resid_data(resid_data), .done(done), .err(err), .nak(nak)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
        return seed + 8'(i * 7);
    endfunction

    // peripheral model: port pops on read, status reacts to host writes
    always @(posedge clk) begin
        if (data_rd && pq.size() > 0) void'(pq.pop_front());
        if (go_tgl != go_seen) begin
            stat_in <= pend_stat;
            go_seen <= go_tgl;
        end else if (stat_wr) begin
            case (stat_wdata)
                8'h70: stat_in <= 8'h10;
                8'h20: if (!hang_data) stat_in <= 8'h40;
                8'h30: stat_in <= 8'h00;
                default: ;
            endcase
        end
    end

    always @(negedge clk) data_in <= (pq.size() > 0) ? pq[0] : 16'h0000;

    // monitor: sets backpressure, then compares what moves at the next edge
    always @(negedge clk) begin
        rcnt++;
        out_ready = (rcnt % 3) != 0;
        if (rst_n) begin
            if (len_valid) begin
                if (exp_len.size() == 0) chk(0, "R3", "unexpected length", len_out, 0);
                else begin
                    logic [15:0] e;
                    e = exp_len.pop_front();
                    chk(len_out == e, "R3", "length", len_out, e);
                end
            end
            if (out_valid && out_ready) begin
                if (exp_byte.size() == 0) chk(0, "R8", "extra payload byte", out_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_byte.pop_front();
                    chk(out_data == e, "R7", "payload byte", out_data, e);
                end
            end
            if (stat_wr) begin
                chk(rx_irq == 1'b1, "R10", "irq with write", rx_irq, 1);
                if (exp_wr.size() == 0) chk(0, "R10", "unexpected write", stat_wdata, 0);
                else begin
                    logic [7:0] e;
                    e = exp_wr.pop_front();
                    chk(stat_wdata == e, "R4", "status write", stat_wdata, e);
                end
            end
        end
    end

    // watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic set_stat(input logic [7:0] v);
        pend_stat = v;
        go_tgl = ~go_tgl;
        @(negedge clk);
    endtask

    task automatic pulse_start(input bit w);
        @(negedge clk);
        wide_mode = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input int lim);
        int n = 0;
        while (!done && !err && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic queues_empty(input string req);
        chk(exp_len.size() == 0, req, "lengths left", exp_len.size(), 0);
        chk(exp_byte.size() == 0, req, "bytes left", exp_byte.size(), 0);
        chk(exp_wr.size() == 0, req, "writes left", exp_wr.size(), 0);
    endtask

    // one good message: build port contents and expected results
    task automatic run_msg(input bit w, input int len, input logic [7:0] seed);
        logic [7:0] pad;
        pad = seed ^ 8'hA5;
        pq.delete();
        if (w) begin
            pq.push_back(16'(len));
            for (int k = 0; k < (len + 1) / 2; k++)
                pq.push_back({(2 * k + 1 < len) ? pbyte(seed, 2 * k + 1) : pad,
                              pbyte(seed, 2 * k)});
        end else begin
            pq.push_back({8'h00, 8'(len)});
            pq.push_back({8'h00, 8'(len >> 8)});
            for (int i = 0; i < len; i++) pq.push_back({8'h00, pbyte(seed, i)});
            if (len % 2 == 1) pq.push_back({8'h00, pad});
            exp_wr.push_back(8'h70);
        end
        exp_len.push_back(16'(len));
        for (int i = 0; i < len; i++) exp_byte.push_back(pbyte(seed, i));
        exp_wr.push_back(8'h20);
        exp_wr.push_back(8'h30);
        pulse_start(w);
        repeat (3) @(negedge clk);
        set_stat(w ? 8'h10 : 8'h60);
        wait_end(4000);
        chk(done == 1'b1, "R9", "done pulse", done, 1);
        chk(err == 1'b0, "R9", "err after good message", err, 0);
        chk(resid_valid == 1'(len % 2), "R8", "residual flag", resid_valid, len % 2);
        if (len % 2 == 1) chk(resid_data == pad, "R8", "residual byte", resid_data, pad);
        @(negedge clk);
        queues_empty("R7");
    endtask

    // request stage failure: code 0 means the peripheral never answers
    task automatic run_bad(input bit w, input logic [7:0] code, input bit exp_nak,
                           input logic [15:0] lim);
        pq.delete();
        poll_limit = lim;
        pulse_start(w);
        if (code != 8'h00) set_stat(code);
        else begin
            repeat (3) @(negedge clk);
            chk(err == 1'b0, "R2", "err before limit", err, 0);
        end
        wait_end(200);
        chk(err == 1'b1, "R5", "err flag", err, 1);
        chk(nak == exp_nak, "R5", "nak flag", nak, exp_nak);
        @(negedge clk);
        queues_empty("R2");
        set_stat(8'h00);
        poll_limit = 16'd50;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({stat_wr, rx_irq, data_rd, len_valid, out_valid, done, err, nak, resid_valid} == '0,
            "R1", "outputs in reset", {stat_wr, rx_irq, data_rd, len_valid, out_valid, done, err, nak, resid_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({stat_wr, data_rd, len_valid, out_valid, done, err, nak} == '0,
            "R1", "outputs after reset", {stat_wr, data_rd, len_valid, out_valid, done, err, nak}, 0);

        run_msg(1'b1, 6, 8'h11);     // R3 wide even
        run_msg(1'b1, 5, 8'h40);     // R8 wide odd
        run_msg(1'b0, 4, 8'h23);     // R4 narrow even
        run_msg(1'b0, 3, 8'h9C);     // R8 narrow odd
        run_msg(1'b0, 300, 8'h05);   // R4 narrow length above 255
        run_msg(1'b1, 0, 8'h00);     // R6 empty payload

        run_bad(1'b1, 8'h50, 1'b1, 16'd50);  // R5 refusal
        run_bad(1'b1, 8'h60, 1'b0, 16'd50);  // R5 wrong width code
        run_bad(1'b0, 8'h10, 1'b0, 16'd50);  // R5 wrong width code, narrow
        run_bad(1'b1, 8'h00, 1'b0, 16'd8);   // R2 request timeout

        run_msg(1'b1, 2, 8'h77);     // R9 flags cleared by next start
        chk(nak == 1'b0, "R9", "nak cleared", nak, 0);

        // R6 data stage timeout
        hang_data = 1'b1;
        pq.delete();
        pq.push_back(16'd2);
        exp_len.push_back(16'd2);
        exp_wr.push_back(8'h20);
        pulse_start(1'b1);
        set_stat(8'h10);
        repeat (100) @(negedge clk);
        chk(err == 1'b0, "R6", "err before stage limit", err, 0);
        wait_end(2000);
        chk(err == 1'b1, "R6", "data stage timeout", err, 1);
        @(negedge clk);
        queues_empty("R6");
        hang_data = 1'b0;
        set_stat(8'h00);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule